// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns parallel data words into asynchronous serial frames on a single output line. Each frame has one low start bit, eight or nine data bits sent least significant bit first, and a high stop interval. Five configuration inputs shape the frame. A long-word select picks eight or nine data bits. A parity enable and a parity sense select even or odd parity. A two-bit stop code picks a stop interval of half, one, one and a half or two bit periods. All bit timing comes from a one-cycle tick supplied at sixteen times the bit rate. The block does not generate that tick itself.

The host writes a word with a one-cycle load strobe. The word goes into a single holding slot. A frame starts from the slot once transmission is enabled. A word loaded during a frame waits in the slot and then follows with no idle gap. A one-cycle done pulse marks the end of the last frame in a burst. A module enable works as a synchronous clear. While it is low, the line idles high and nothing is stored.

Top module: `serFrameTx`

## Requirements
- R1: After reset, and whenever the module enable is low, the output line is high (idle). After reset the busy output and the done pulse are low.
- R2: Each frame starts with a low start bit. The data bits follow, least significant first, and the stop interval is high. Every start and data bit lasts exactly 16 ticks.
- R3: When the long-word select is 0, the frame carries data bits 0 to 7 and bit 8 of the input is never sent. When the select is 1, the frame carries data bits 0 to 8.
- R4: When parity is enabled, the last data position (bit 7 for short words, bit 8 for long words) carries a parity bit in place of that data bit. The parity bit is the XOR of the data bits sent before it, inverted when the parity sense is 1 (0 is even, 1 is odd). When parity is disabled, that position carries the data bit.
- R5: The stop interval lasts 16 ticks for stop code 00, 8 ticks for 01, 32 ticks for 10 and 24 ticks for 11.
- R6: While the transmit enable is low, no frame is started. A word loaded in that time stays held (busy high, line high) and is sent once the enable rises.
- R7: A word loaded while a frame is in progress is held and sent immediately after the current stop interval, with no idle cycle. A load that arrives while the holding slot is already full is ignored.
- R8: The done output pulses high for exactly one cycle, in the cycle after the last stop tick. It pulses only when no held word follows. Between back-to-back frames it stays low.
- R9: Dropping the module enable aborts any frame in progress and discards the held word. Busy goes low within one cycle. Loads made while the enable is low are ignored.
- R10: State changes inside a frame happen only on cycles where the tick is high, so a sparser tick stretches the frame in proportion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modEn | input | 1 | Module enable; low clears the block and idles the line |
| txEn | input | 1 | Transmit enable; gates the start of new frames |
| tick | input | 1 | One-cycle oversampling tick at 16x the bit rate |
| wordLong | input | 1 | 0: eight data bits, 1: nine data bits |
| parEn | input | 1 | Parity replaces the last data bit when high |
| parOdd | input | 1 | Parity sense: 0 even, 1 odd |
| stopCode | input | 2 | Stop length: 00 one, 01 half, 10 two, 11 one and a half bit periods |
| dataIn | input | 9 | Word to transmit |
| load | input | 1 | Strobe that writes dataIn into the holding slot |
| txLine | output | 1 | Serial output line |
| busy | output | 1 | High while a frame is in progress or a word is held |
| frameDone | output | 1 | One-cycle pulse at the end of the last frame |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and a 9-bit maximum word. For most runs the tick is held high every cycle, so each tick is one clock. That makes every bit and stop boundary an exact cycle number the bench can predict arithmetically. With this setting, a full sweep is short enough to run: both word lengths, three parity modes, all four stop codes and a set of data patterns with single-bit, all-ones and alternating values. A separate run uses a tick every third cycle. It shows that the timing follows the tick and not the clock.

// File: rtl/serTxPkg.sv
package serTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txStateT;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic beginFrame;
    logic nextBit;
    logic sendParity;
    logic beginStop;
    logic finish;
  } txStrobeT;

  // frame shape latched by the control at frame start
  typedef struct packed {
    logic       wordLong;
    logic       parEn;
    logic [1:0] stopCode;
  } txCfgT;

endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     modEn,
  input  logic     txEn,
  input  logic     tick,
  input  logic     holdValid,
  input  txCfgT    cfgIn,
  output txStrobeT strobe,
  output logic     active,
  output logic     frameDone
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int IDX_W = $clog2(MAX_BITS + 1);

  localparam logic [CNT_W-1:0] BIT_LAST      = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP_HALF     = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] STOP_ONE      = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] STOP_ONEHALF  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] STOP_TWO      = CNT_W'(2 * TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] LONG_BITS     = IDX_W'(MAX_BITS);
  localparam logic [IDX_W-1:0] SHORT_BITS    = IDX_W'(MAX_BITS - 1);

  txStateT          stateQ;
  logic [CNT_W-1:0] tickCntQ;
  logic [IDX_W-1:0] bitIdxQ;
  txCfgT            cfgQ;
  logic             doneQ;

  logic [IDX_W-1:0] dataBits;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] newIdx;
  logic [CNT_W-1:0] stopLast;
  logic             bitEnd;
  logic             stopEnd;
  logic             canStart;

  assign dataBits = cfgQ.wordLong ? LONG_BITS : SHORT_BITS;
  assign lastIdx  = dataBits - IDX_W'(1);
  assign bitEnd   = tick && (tickCntQ == BIT_LAST);
  assign stopEnd  = tick && (tickCntQ == stopLast);
  assign canStart = holdValid && txEn;
  assign newIdx   = (stateQ == ST_START) ? '0 : bitIdxQ + IDX_W'(1);

  always_comb begin
    case (cfgQ.stopCode)
      2'b00:   stopLast = STOP_ONE;
      2'b01:   stopLast = STOP_HALF;
      2'b10:   stopLast = STOP_TWO;
      default: stopLast = STOP_ONEHALF;
    endcase
  end

  always_comb begin
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: strobe.beginFrame = canStart;
      ST_START: begin
        strobe.nextBit    = bitEnd;
        strobe.sendParity = bitEnd && cfgQ.parEn && (newIdx == lastIdx);
      end
      ST_DATA: begin
        if (bitEnd && bitIdxQ == lastIdx) begin
          strobe.beginStop = 1'b1;
        end else if (bitEnd) begin
          strobe.nextBit    = 1'b1;
          strobe.sendParity = cfgQ.parEn && (newIdx == lastIdx);
        end
      end
      ST_STOP: begin
        strobe.beginFrame = stopEnd && canStart;
        strobe.finish     = stopEnd && !canStart;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !modEn) begin
      stateQ   <= ST_IDLE;
      tickCntQ <= '0;
      bitIdxQ  <= '0;
      cfgQ     <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      if (strobe.beginFrame) begin
        stateQ   <= ST_START;
        tickCntQ <= '0;
        bitIdxQ  <= '0;
        cfgQ     <= cfgIn;
      end else if (strobe.nextBit) begin
        stateQ   <= ST_DATA;
        tickCntQ <= '0;
        bitIdxQ  <= newIdx;
      end else if (strobe.beginStop) begin
        stateQ   <= ST_STOP;
        tickCntQ <= '0;
      end else if (strobe.finish) begin
        stateQ   <= ST_IDLE;
        tickCntQ <= '0;
      end else if (tick && stateQ != ST_IDLE) begin
        tickCntQ <= tickCntQ + CNT_W'(1);
      end
    end
  end

  assign active    = (stateQ != ST_IDLE);
  assign frameDone = doneQ;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R10
  tick_align_chk: assert property (@(posedge clk) disable iff (!rstN || !modEn)
    (stateQ != ST_IDLE && !tick) |=> (stateQ == $past(stateQ)));

  // R6
  no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !txEn) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/serTxData.sv
module serTxData
  import serTxPkg::*;
#(
  parameter int MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modEn,
  input  logic                load,
  input  logic [MAX_BITS-1:0] dataIn,
  input  logic                parOddIn,
  input  txStrobeT            strobe,
  output logic                holdValid,
  output logic                lineOut
);

  logic [MAX_BITS-1:0] holdQ;
  logic                holdValidQ;
  logic [MAX_BITS-1:0] shiftQ;
  logic                parAccQ;
  logic                parOddQ;
  logic                lineQ;
  logic                acceptLoad;

  // slot frees up in the same cycle it is drained
  assign acceptLoad = load && (!holdValidQ || strobe.beginFrame);

  always_ff @(posedge clk) begin
    if (!rstN || !modEn) begin
      holdQ      <= '0;
      holdValidQ <= 1'b0;
      shiftQ     <= '0;
      parAccQ    <= 1'b0;
      parOddQ    <= 1'b0;
      lineQ      <= 1'b1;
    end else begin
      if (acceptLoad) begin
        holdQ      <= dataIn;
        holdValidQ <= 1'b1;
      end else if (strobe.beginFrame) begin
        holdValidQ <= 1'b0;
      end

      if (strobe.beginFrame) begin
        shiftQ  <= holdQ;
        parAccQ <= 1'b0;
        parOddQ <= parOddIn;
        lineQ   <= 1'b0;
      end else if (strobe.nextBit && strobe.sendParity) begin
        lineQ <= parAccQ ^ parOddQ;
      end else if (strobe.nextBit) begin
        lineQ   <= shiftQ[0];
        parAccQ <= parAccQ ^ shiftQ[0];
        shiftQ  <= {1'b0, shiftQ[MAX_BITS-1:1]};
      end else if (strobe.beginStop) begin
        lineQ <= 1'b1;
      end
    end
  end

  assign holdValid = holdValidQ;
  assign lineOut   = lineQ;

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN || !modEn)
    (holdValidQ && !strobe.beginFrame) |=> (holdValidQ && $stable(holdQ)));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN || !modEn)
    strobe.beginFrame |=> !lineQ);

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> !holdValidQ);

endmodule

// File: rtl/serFrameTx.sv
module serFrameTx
  import serTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modEn,
  input  logic                txEn,
  input  logic                tick,
  input  logic                wordLong,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic [1:0]          stopCode,
  input  logic [MAX_BITS-1:0] dataIn,
  input  logic                load,
  output logic                txLine,
  output logic                busy,
  output logic                frameDone
);

  txStrobeT strobe;
  txCfgT    cfgIn;
  logic     holdValid;
  logic     active;
  logic     lineRaw;

  assign cfgIn = '{wordLong: wordLong, parEn: parEn, stopCode: stopCode};

  serTxCtrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .MAX_BITS     (MAX_BITS)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modEn    (modEn),
    .txEn     (txEn),
    .tick     (tick),
    .holdValid(holdValid),
    .cfgIn    (cfgIn),
    .strobe   (strobe),
    .active   (active),
    .frameDone(frameDone)
  );

  serTxData #(
    .MAX_BITS(MAX_BITS)
  ) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .modEn    (modEn),
    .load     (load),
    .dataIn   (dataIn),
    .parOddIn (parOdd),
    .strobe   (strobe),
    .holdValid(holdValid),
    .lineOut  (lineRaw)
  );

  assign txLine = modEn ? lineRaw : 1'b1;
  assign busy   = active || holdValid;

endmodule

// File: tb/serFrameTx_test.sv
module serFrameTx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modEn = 1'b1;
  logic       txEn = 1'b1;
  logic       tick;
  logic       wordLong = 1'b0;
  logic       parEn = 1'b0;
  logic       parOdd = 1'b0;
  logic [1:0] stopCode = 2'b00;
  logic [8:0] dataIn = '0;
  logic       load = 1'b0;
  logic       txLine, busy, frameDone;

  int testCnt = 0;
  int failCnt = 0;
  int tickDiv = 1;
  int tickPhase = 0;

  always #4 clk = ~clk;

  assign tick = (tickDiv == 1) ? 1'b1 : (tickPhase == 0);
  always @(negedge clk) tickPhase <= (tickPhase + 1 >= tickDiv) ? 0 : tickPhase + 1;

  serFrameTx uut (
    .clk(clk), .rstN(rstN), .modEn(modEn), .txEn(txEn), .tick(tick),
    .wordLong(wordLong), .parEn(parEn), .parOdd(parOdd), .stopCode(stopCode),
    .dataIn(dataIn), .load(load), .txLine(txLine), .busy(busy), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stopTicks(input logic [1:0] sc);
    case (sc)
      2'b00: return 16;
      2'b01: return 8;
      2'b10: return 32;
      default: return 24;
    endcase
  endfunction

  task automatic loadWord(input logic [8:0] d);
    dataIn = d;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Called at a negedge; waits for the start bit, checks bits and stop length.
  task automatic expectFrame(input logic [8:0] d, input bit follows);
    int n = wordLong ? 9 : 8;
    int waited = 0;
    int j = 0;
    bit doneSeen = 0;
    logic [9:0] got = '0;
    logic [9:0] exp = '0;
    logic par = 1'b0;
    while (txLine !== 1'b0 && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    check(txLine === 1'b0, "R2", "start bit seen (wait cycles)", waited, 2);
    for (int i = 0; i < n; i++) begin
      if (parEn && i == n - 1) exp[i+1] = par ^ parOdd;
      else begin
        exp[i+1] = d[i];
        par = par ^ d[i];
      end
    end
    for (int c = 0; c < (n + 1) * 16; c++) begin
      if (c % 16 == 8) got[c/16] = txLine;
      if (frameDone) doneSeen = 1;
      @(negedge clk);
    end
    check(got == exp && !doneSeen, "R2 R3 R4", "start+data bits", int'(got), int'(exp));
    while (j < 80) begin
      if (frameDone || txLine !== 1'b1) break;
      j++;
      @(negedge clk);
    end
    if (follows)
      check(txLine === 1'b0 && !frameDone && j == stopTicks(stopCode), "R5 R7 R8",
            "stop length before back-to-back start", j, stopTicks(stopCode));
    else
      check(frameDone === 1'b1 && txLine === 1'b1 && j == stopTicks(stopCode), "R5 R8",
            "stop length before done pulse", j, stopTicks(stopCode));
  endtask

  task automatic expectQuiet(input int cycles, input string req, input bit expBusy);
    bit allHigh = 1;
    bit busyOk = 1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || frameDone) allHigh = 0;
      if (busy !== expBusy) busyOk = 0;
    end
    check(allHigh && busyOk, req, "line idle and busy level", int'(busy), int'(expBusy));
  endtask

  initial begin
    logic [8:0] pats [6] = '{9'h000, 9'h1FF, 9'h0A5, 9'h15A, 9'h101, 9'h0FE};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txLine === 1'b1, "R1", "line after reset", int'(txLine), 1);
    check(busy === 1'b0 && frameDone === 1'b0, "R1", "busy/done after reset", int'(busy), 0);

    // sweep: word length x parity mode x stop code x data
    for (int w = 0; w < 2; w++)
      for (int pm = 0; pm < 3; pm++)
        for (int sc = 0; sc < 4; sc++)
          foreach (pats[k]) begin
            wordLong = w[0];
            parEn    = (pm != 0);
            parOdd   = (pm == 2);
            stopCode = sc[1:0];
            loadWord(pats[k]);
            expectFrame(pats[k], 1'b0);
            @(negedge clk);
          end

    // R7 back-to-back, third load ignored while slot full
    wordLong = 1'b0; parEn = 1'b1; parOdd = 1'b1; stopCode = 2'b01;
    loadWord(9'h0C3);
    fork
      expectFrame(9'h0C3, 1'b1);
      begin
        repeat (5) @(negedge clk);
        loadWord(9'h03C);
        loadWord(9'h1E1);
      end
    join
    expectFrame(9'h03C, 1'b0);
    expectQuiet(60, "R7", 1'b0);

    // R6 transmit enable low holds the word
    txEn = 1'b0; stopCode = 2'b10; parEn = 1'b0;
    loadWord(9'h05A);
    expectQuiet(50, "R6", 1'b1);
    txEn = 1'b1;
    expectFrame(9'h05A, 1'b0);
    @(negedge clk);

    // R9 module enable drop aborts and discards
    stopCode = 2'b00;
    loadWord(9'h000);
    repeat (40) @(negedge clk);
    modEn = 1'b0;
    #1;
    check(txLine === 1'b1, "R1 R9", "line high when disabled", int'(txLine), 1);
    @(negedge clk);
    check(busy === 1'b0, "R9", "busy cleared", int'(busy), 0);
    loadWord(9'h0AA);
    modEn = 1'b1;
    expectQuiet(60, "R9", 1'b0);

    // R10 sparse tick stretches the frame
    tickDiv = 3;
    wordLong = 1'b0; parEn = 1'b0; stopCode = 2'b00;
    loadWord(9'h033);
    begin
      int w = 0;
      int len = 0;
      while (txLine !== 1'b0 && w < 20) begin @(negedge clk); w++; end
      while (!frameDone && len < 1000) begin @(negedge clk); len++; end
      check(len >= 3 * 160 - 3 && len <= 3 * 160 + 3, "R10", "frame cycles at 1/3 tick", len, 480);
    end
    tickDiv = 1;

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule